// File: doc/BRIEF.md
# Content Addressable Match Memory

This block is a small register-based store that behaves like an ordinary RAM for addressed reads and writes and also answers the question "which words hold this value?". A search presents a key on the shared data input. The block compares that key against every stored word in the same cycle. It returns one hit bit per word and a single miss flag that is raised when no word matches.

Each word carries a valid bit that is set by its first write and cleared by reset. A word that has never been written can therefore never report a hit, even when its cleared contents equal the key. Reads, writes and searches may be issued in the same cycle. Reads and searches always see the contents as they stood before any write in that cycle.

Top module: `cam_match_mem`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `rd_data`, `hit_vec` and `miss` are all zero. Reset also marks every word invalid, so a search for key 0 right after reset returns `hit_vec` = 0 and `miss` = 1.
- R2: With `wr_en` high at a clock edge, the value on `din` is stored in word `addr` and that word becomes valid.
- R3: With `rd_en` high at a clock edge, `rd_data` shows the contents of word `addr` after that edge. With `rd_en` low, `rd_data` keeps its value.
- R4: A read and a write to the same address at the same edge return the contents from before the write. The new value is seen by later reads.
- R5: With `srch_en` high at a clock edge, after that edge bit i of `hit_vec` is 1 exactly when word i is valid and equal to `din`. Several bits may be set at once.
- R6: Each search also registers `miss`, which is 1 exactly when no bit of the new `hit_vec` is set.
- R7: With `srch_en` low at a clock edge, `hit_vec` and `miss` keep their values.
- R8: A search changes neither stored contents nor valid bits. A read after a search returns the same words, and a repeated search returns the same result.
- R9: A search and a write at the same edge compare the key against the contents from before the write. The write still takes effect for later operations.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | AW = clog2(N) | Word address for read and write |
| din | input | W | Write data, or search key |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| srch_en | input | 1 | Search strobe |
| rd_data | output | W | Registered read result |
| hit_vec | output | N | Registered per-word hit bits |
| miss | output | 1 | Registered flag, high when the last search found no word |

## Verification
All three results are due one clock after their strobe. `rd_data` follows `rd_en`, while `hit_vec` and `miss` follow `srch_en`. Between strobes each result holds its value. The bench drives each operation on the falling edge and lets a behavioural model update in the same step. It then waits past the next rising edge and compares all outputs on the following falling edge, so every comparison lands exactly one register stage after its stimulus. Same-edge combinations (read with write, search with write) are modelled by evaluating the read and the search before applying the write.

// File: rtl/cam_pkg.sv
package cam_pkg;

    // Address width for a store of n words; at least one bit.
    function automatic int unsigned addr_bits(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

    // Operation strobes presented in one cycle.
    typedef struct packed {
        logic rd;
        logic wr;
        logic srch;
    } cam_op_t;

    // Search outcome class, used for readability of the collect stage.
    typedef enum logic [1:0] {
        SR_NONE  = 2'd0,
        SR_MISS  = 2'd1,
        SR_HIT   = 2'd2
    } srch_kind_t;

    function automatic srch_kind_t classify(input logic any_hit);
        return any_hit ? SR_HIT : SR_MISS;
    endfunction

endpackage

// File: rtl/cam_word_row.sv
module cam_word_row #(
    parameter int unsigned W   = 8,
    parameter int unsigned AW  = 2,
    parameter int unsigned IDX = 0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [W-1:0]  din,
    output logic [W-1:0]  word_q,
    output logic          valid_q,
    output logic          eq
);
    logic row_sel;

    assign row_sel = wr_en && (addr == AW'(IDX));

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q  <= '0;
            valid_q <= 1'b0;
        end else if (row_sel) begin
            word_q  <= din;
            valid_q <= 1'b1;
        end
    end

    // Comparison uses the value held before this cycle's edge.
    assign eq = valid_q && (word_q == din);
endmodule

// File: rtl/cam_read_port.sv
module cam_read_port #(
    parameter int unsigned N  = 4,
    parameter int unsigned W  = 8,
    parameter int unsigned AW = 2
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           rd_en,
    input  logic [AW-1:0]  addr,
    input  logic [N*W-1:0] words,
    output logic [W-1:0]   rd_data
);
    logic [W-1:0] sel_word;

    always_comb begin
        sel_word = '0;
        for (int i = 0; i < int'(N); i++) begin
            if (addr == AW'(i)) begin
                sel_word = words[i*W +: W];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data <= '0;
        end else if (rd_en) begin
            rd_data <= sel_word;
        end
    end
endmodule

// File: rtl/cam_hit_collect.sv
module cam_hit_collect #(
    parameter int unsigned N = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         srch_en,
    input  logic [N-1:0] eq_vec,
    output logic [N-1:0] hit_vec,
    output logic         miss
);
    cam_pkg::srch_kind_t kind;

    assign kind = cam_pkg::classify(|eq_vec);

    always_ff @(posedge clk) begin
        if (rst) begin
            hit_vec <= '0;
            miss    <= 1'b0;
        end else if (srch_en) begin
            hit_vec <= eq_vec;
            miss    <= (kind == cam_pkg::SR_MISS);
        end
    end
endmodule

// File: rtl/cam_match_mem.sv
module cam_match_mem #(
    parameter  int unsigned N  = 4,
    parameter  int unsigned W  = 8,
    localparam int unsigned AW = cam_pkg::addr_bits(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] addr,
    input  logic [W-1:0]  din,
    input  logic          rd_en,
    input  logic          wr_en,
    input  logic          srch_en,
    output logic [W-1:0]  rd_data,
    output logic [N-1:0]  hit_vec,
    output logic          miss
);
    cam_pkg::cam_op_t op;
    logic [N*W-1:0]   words;
    logic [N-1:0]     eq_vec;
    logic [N-1:0]     valid_vec;

    assign op = '{rd: rd_en, wr: wr_en, srch: srch_en};

    for (genvar g = 0; g < int'(N); g++) begin : g_row
        cam_word_row #(.W(W), .AW(AW), .IDX(g)) u_row (
            .clk     (clk),
            .rst     (rst),
            .wr_en   (op.wr),
            .addr    (addr),
            .din     (din),
            .word_q  (words[g*W +: W]),
            .valid_q (valid_vec[g]),
            .eq      (eq_vec[g])
        );
    end

    cam_read_port #(.N(N), .W(W), .AW(AW)) u_rd (
        .clk     (clk),
        .rst     (rst),
        .rd_en   (op.rd),
        .addr    (addr),
        .words   (words),
        .rd_data (rd_data)
    );

    cam_hit_collect #(.N(N)) u_hit (
        .clk     (clk),
        .rst     (rst),
        .srch_en (op.srch),
        .eq_vec  (eq_vec),
        .hit_vec (hit_vec),
        .miss    (miss)
    );
endmodule

// File: rtl/cam_match_mem_chk.sv
module cam_match_mem_chk #(
    parameter int unsigned N  = 4,
    parameter int unsigned W  = 8
) (
    input logic         clk,
    input logic         rst,
    input logic         rd_en,
    input logic         srch_en,
    input logic [W-1:0] rd_data,
    input logic [N-1:0] hit_vec,
    input logic         miss
);
    logic rst_q;
    logic rd_q;
    logic srch_q;

    always_ff @(posedge clk) begin
        rst_q  <= rst;
        rd_q   <= rd_en && !rst;
        srch_q <= srch_en && !rst;
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
        rst_q |-> (rd_data == '0 && hit_vec == '0 && !miss));

    // R3
    rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!rd_q && !rst_q) |-> $stable(rd_data));

    // R6
    miss_nor_chk: assert property (@(posedge clk) disable iff (rst)
        srch_q |-> (miss == (hit_vec == '0)));

    // R7
    result_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!srch_q && !rst_q) |-> ($stable(hit_vec) && $stable(miss)));
endmodule

bind cam_match_mem cam_match_mem_chk #(.N(N), .W(W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .rd_en   (rd_en),
    .srch_en (srch_en),
    .rd_data (rd_data),
    .hit_vec (hit_vec),
    .miss    (miss)
);

// File: tb/sim_cam_match_mem.sv
`timescale 1ns/1ps
module sim_cam_match_mem;
    localparam int N  = 4;
    localparam int W  = 8;
    localparam int AW = 2;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [W-1:0]  din = '0;
    logic          rd_en = 1'b0;
    logic          wr_en = 1'b0;
    logic          srch_en = 1'b0;
    logic [W-1:0]  rd_data;
    logic [N-1:0]  hit_vec;
    logic          miss;

    int checks = 0;
    int failures = 0;

    // Behavioural reference state
    int          m_word [N];
    bit          m_valid [N];
    int          e_rd = 0;
    int          e_hit = 0;
    bit          e_miss = 0;

    always #4 clk = ~clk;

    cam_match_mem #(.N(N), .W(W)) u0 (
        .clk(clk), .rst(rst), .addr(addr), .din(din),
        .rd_en(rd_en), .wr_en(wr_en), .srch_en(srch_en),
        .rd_data(rd_data), .hit_vec(hit_vec), .miss(miss)
    );

    task automatic check(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic compare_all(input string tag);
        check(tag, "rd_data", int'(rd_data), e_rd);
        check(tag, "hit_vec", int'(hit_vec), e_hit);
        check(tag, "miss", int'(miss), int'(e_miss));
    endtask

    // Called at a falling edge: drive one operation, update model, compare one edge later.
    task automatic op(input bit r, input bit w, input bit s, input int a, input int d, input string tag);
        int h;
        rd_en = r; wr_en = w; srch_en = s;
        addr = AW'(a); din = W'(d);
        if (r) e_rd = m_word[a];
        if (s) begin
            h = 0;
            for (int i = 0; i < N; i++)
                if (m_valid[i] && m_word[i] == d) h |= (1 << i);
            e_hit = h;
            e_miss = (h == 0);
        end
        if (w) begin
            m_word[a] = d;
            m_valid[a] = 1'b1;
        end
        @(posedge clk);
        @(negedge clk);
        rd_en = 1'b0; wr_en = 1'b0; srch_en = 1'b0;
        compare_all(tag);
    endtask

    initial begin
        #1_000_000;
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        for (int i = 0; i < N; i++) begin
            m_word[i] = 0;
            m_valid[i] = 1'b0;
        end
        repeat (3) @(negedge clk);
        check("R1", "rd_data in reset", int'(rd_data), 0);
        rst = 1'b0;
        @(negedge clk);
        compare_all("R1");
        // R1: reset leaves every word invalid, so key 0 misses
        op(0, 0, 1, 0, 8'h00, "R1");
        // R2: fill the store
        op(0, 1, 0, 0, 8'h3C, "R2");
        op(0, 1, 0, 1, 8'hA5, "R2");
        op(0, 1, 0, 2, 8'h3C, "R2");
        op(0, 1, 0, 3, 8'h7E, "R2");
        // R3: read back each word
        for (int i = 0; i < N; i++) op(1, 0, 0, i, 0, "R3");
        // R5: several hits, single hit; R6: no hit
        op(0, 0, 1, 0, 8'h3C, "R5");
        op(0, 0, 1, 0, 8'h7E, "R5");
        op(0, 0, 1, 0, 8'h11, "R6");
        op(0, 0, 1, 0, 8'hA5, "R6");
        // R7: idle cycles with data changing, results hold
        op(0, 0, 0, 2, 8'h3C, "R7");
        op(0, 0, 0, 1, 8'h00, "R7");
        // R8: search then read and repeat search
        op(1, 0, 1, 1, 8'h3C, "R8");
        op(1, 0, 0, 0, 0, "R8");
        op(1, 0, 0, 2, 0, "R8");
        op(0, 0, 1, 0, 8'h3C, "R8");
        // R4: read and write same address at one edge
        op(1, 1, 0, 1, 8'h99, "R4");
        op(1, 0, 0, 1, 0, "R4");
        // R9: write and search same edge use old contents
        op(0, 1, 1, 3, 8'h5A, "R9");
        op(0, 0, 1, 0, 8'h5A, "R9");
        op(0, 1, 1, 0, 8'h5A, "R9");
        op(0, 0, 1, 0, 8'h5A, "R9");
        // R5: mixed random operations over a small value set
        for (int k = 0; k < 300; k++) begin
            op(bit'($urandom_range(0, 1)), bit'($urandom_range(0, 1)),
               bit'($urandom_range(0, 1)), int'($urandom_range(0, N - 1)),
               int'($urandom_range(0, 3)) * 8'h11, "R5");
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule